// File: doc/BRIEF.md
# Low-Speed USB Packet Transmitter

This block puts a packet on a low-speed USB differential pair. On a start request it first drives the idle J level with its drivers still off, then turns the drivers on and sends an internally generated sync byte. It then sends the packet bytes, which it pulls one at a time from a byte source. Every byte goes out least significant bit first, NRZI encoded, with a stuffed zero after every run of six ones. The packet closes with two bit times of SE0 and one bit time of J, after which the drivers turn off.

The packet length counts the sync byte. A length of two means a handshake (sync plus one PID byte). A longer length means a data packet. A device-address update that firmware has staged is committed through a one-cycle strobe only when a data packet finishes, so an ACK or NAK sent in between never moves the address. The bit period is a fixed number of clock cycles with no fractional correction, which is within the 1.5 % rate tolerance.

Top module: `usb_ls_tx`

## Requirements
- R1: After reset and whenever no packet is in progress, oe, dp, dm, busy, done, addr_commit and byte_next are all 0.
- R2: A start accepted while idle gives exactly one clock cycle with dp=0, dm=1 (J) and oe=0. oe then rises in the next cycle, and the first bit begins in that cycle.
- R3: Every line symbol, including the end-of-packet symbols, holds for exactly CLKS_PER_BIT clock cycles.
- R4: The first byte sent is the sync value 0x80, least significant bit first. With J = (dp=0, dm=1) and K = (dp=1, dm=0), it appears as K J K J K J K K.
- R5: Bytes go out least significant bit first, NRZI encoded: a 0 bit toggles the line between J and K, and a 1 bit keeps the previous level. The level before the first bit is J.
- R6: After six consecutive 1 bits the block inserts one extra toggle. The run count starts at zero with the sync byte, carries across byte boundaries, and is cleared by a 0 bit or a stuffed bit. A stuff that falls due after the final bit is still sent before the end of packet.
- R7: For a clamped length L, exactly L-1 single-cycle byte_next pulses occur. Each pulse marks the cycle in which byte_in is taken, and the bytes are sent in the order taken.
- R8: A pkt_len below 2 is treated as 2, and a pkt_len above 12 is treated as 12.
- R9: After the last data or stuff symbol, the block drives SE0 (dp=0, dm=0) for two bit times and then J for one bit time, with oe=1 throughout. dp and dm are never both 1.
- R10: busy is 1 from the cycle after the start is accepted through the last cycle of the final J. done is a one-cycle pulse in the cycle where oe falls back to 0.
- R11: addr_commit pulses together with done only when the clamped length is above 2 and addr_pending is 1 at release. It never fires after a 2-byte handshake or while addr_pending is 0.
- R12: A start request while busy is ignored, and the packet in progress is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request to send a packet, sampled while idle |
| pkt_len | input | LEN_W | Packet length in bytes including sync |
| byte_in | input | 8 | Next packet byte offered by the source |
| addr_pending | input | 1 | A new device address is staged |
| byte_next | output | 1 | One-cycle pulse: byte_in taken, present the next byte |
| busy | output | 1 | Packet in progress |
| done | output | 1 | One-cycle pulse at bus release |
| addr_commit | output | 1 | One-cycle strobe to commit the staged address |
| dp | output | 1 | D+ line level |
| dm | output | 1 | D- line level |
| oe | output | 1 | Line driver enable |

## Verification
The hardest situation to reach from the ports is a stuff that falls due exactly at a byte boundary, or after the very last bit. There the stuffed toggle must be sent before the next byte is taken, or before SE0 begins. The vector table places runs of ones in the fetched bytes that straddle byte boundaries and end the packet. The bench decodes the line at every clock of every bit, undoes NRZI and stuffing on its own, and compares the recovered bits, the symbol count and the byte_next count with values computed from the table.

// File: rtl/usbtx_pkg.sv
package usbtx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PREP,
    PH_DATA,
    PH_SE0A,
    PH_SE0B,
    PH_JEND
  } phase_t;

  localparam logic [7:0] SYNC_PATTERN = 8'h80;
  localparam int         STUFF_LIMIT  = 6;
  localparam int         MIN_LEN      = 2;
  localparam int         MAX_LEN      = 12;
  localparam int         BITS_PER_BYTE = 8;

endpackage

// File: rtl/usbtx_bit_timer.sv
module usbtx_bit_timer #(
  parameter int CLKS_PER_BIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == LAST);
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  generate
    if (CLKS_PER_BIT > 1) begin : g_spacing
      // R3
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/usbtx_bit_source.sv
module usbtx_bit_source
  import usbtx_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] n_bytes,
  input  logic             advance,
  input  logic [7:0]       byte_in,
  output logic             need_toggle,
  output logic             bits_done,
  output logic             byte_next
);

  localparam int RUN_W = $clog2(STUFF_LIMIT + 1);
  localparam int BIT_W = $clog2(BITS_PER_BYTE + 1);
  localparam logic [RUN_W-1:0] RUN_CAP  = RUN_W'(STUFF_LIMIT);
  localparam logic [BIT_W-1:0] BIT_FULL = BIT_W'(BITS_PER_BYTE);

  logic [7:0]       shift_q, shift_d;
  logic [BIT_W-1:0] bits_q, bits_d;
  logic [LEN_W-1:0] left_q, left_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic             stuff_now;

  always_comb begin
    stuff_now   = (run_q == RUN_CAP);
    need_toggle = stuff_now || !shift_q[0];
    bits_done   = !stuff_now && (bits_q == '0);

    shift_d   = shift_q;
    bits_d    = bits_q;
    left_d    = left_q;
    run_d     = run_q;
    byte_next = 1'b0;

    if (load) begin
      shift_d = SYNC_PATTERN;
      bits_d  = BIT_FULL;
      left_d  = n_bytes - 1'b1;
      run_d   = '0;
    end else if (advance) begin
      if (stuff_now) begin
        run_d = '0;
      end else if (bits_q != '0) begin
        run_d = shift_q[0] ? run_q + 1'b1 : '0;
        if ((bits_q == BIT_W'(1)) && (left_q != '0)) begin
          shift_d   = byte_in;
          bits_d    = BIT_FULL;
          left_d    = left_q - 1'b1;
          byte_next = 1'b1;
        end else begin
          shift_d = {1'b0, shift_q[7:1]};
          bits_d  = bits_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      bits_q  <= '0;
      left_q  <= '0;
      run_q   <= '0;
    end else if (load || advance) begin
      shift_q <= shift_d;
      bits_q  <= bits_d;
      left_q  <= left_d;
      run_q   <= run_d;
    end
  end

  // R6
  run_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_CAP);

  // R7
  fetch_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_next |=> !byte_next);

endmodule

// File: rtl/usbtx_line_ctrl.sv
module usbtx_line_ctrl
  import usbtx_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len_raw,
  input  logic             addr_pending,
  input  logic             tick,
  input  logic             need_toggle,
  input  logic             bits_done,
  output logic             load,
  output logic             advance,
  output logic             timer_run,
  output logic [LEN_W-1:0] n_bytes,
  output logic             busy,
  output logic             dp,
  output logic             dm,
  output logic             oe,
  output logic             done,
  output logic             addr_commit
);

  localparam logic [LEN_W-1:0] LEN_LO = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] LEN_HI = LEN_W'(MAX_LEN);

  phase_t phase_q, phase_d;
  logic   lvl_q, lvl_d;          // 1 = K, 0 = J
  logic   data_q, data_d;
  logic   dp_q, dp_d, dm_q, dm_d, oe_q, oe_d;
  logic   done_q, done_d, commit_q, commit_d;

  always_comb begin
    if (len_raw < LEN_LO)      n_bytes = LEN_LO;
    else if (len_raw > LEN_HI) n_bytes = LEN_HI;
    else                       n_bytes = len_raw;

    load      = (phase_q == PH_IDLE) && start;
    advance   = (phase_q == PH_PREP) ||
                ((phase_q == PH_DATA) && tick && !bits_done);
    timer_run = (phase_q != PH_IDLE) && (phase_q != PH_PREP);
    busy      = (phase_q != PH_IDLE);

    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (start) phase_d = PH_PREP;
      PH_PREP: phase_d = PH_DATA;
      PH_DATA: if (tick && bits_done) phase_d = PH_SE0A;
      PH_SE0A: if (tick) phase_d = PH_SE0B;
      PH_SE0B: if (tick) phase_d = PH_JEND;
      PH_JEND: if (tick) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase

    lvl_d = lvl_q;
    if (load)         lvl_d = 1'b0;
    else if (advance) lvl_d = lvl_q ^ need_toggle;

    data_d = data_q;
    if (load) data_d = (n_bytes > LEN_LO);

    dp_d = 1'b0;
    dm_d = 1'b0;
    oe_d = 1'b0;
    unique case (phase_d)
      PH_IDLE: begin dp_d = 1'b0;  dm_d = 1'b0;   oe_d = 1'b0; end
      PH_PREP: begin dp_d = 1'b0;  dm_d = 1'b1;   oe_d = 1'b0; end
      PH_DATA: begin dp_d = lvl_d; dm_d = !lvl_d; oe_d = 1'b1; end
      PH_SE0A,
      PH_SE0B: begin dp_d = 1'b0;  dm_d = 1'b0;   oe_d = 1'b1; end
      PH_JEND: begin dp_d = 1'b0;  dm_d = 1'b1;   oe_d = 1'b1; end
      default: begin dp_d = 1'b0;  dm_d = 1'b0;   oe_d = 1'b0; end
    endcase

    done_d   = (phase_q == PH_JEND) && tick;
    commit_d = done_d && data_q && addr_pending;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      lvl_q    <= 1'b0;
      data_q   <= 1'b0;
      dp_q     <= 1'b0;
      dm_q     <= 1'b0;
      oe_q     <= 1'b0;
      done_q   <= 1'b0;
      commit_q <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      lvl_q    <= lvl_d;
      if (load) data_q <= data_d;
      dp_q     <= dp_d;
      dm_q     <= dm_d;
      oe_q     <= oe_d;
      done_q   <= done_d;
      commit_q <= commit_d;
    end
  end

  assign dp          = dp_q;
  assign dm          = dm_q;
  assign oe          = oe_q;
  assign done        = done_q;
  assign addr_commit = commit_q;

  // R9
  no_both_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> !(dp_q && dm_q));

  // R2
  acquire_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> ($past(dm_q) && !$past(dp_q)));

  // R10
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!oe_q && (phase_q == PH_IDLE)));

  // R9
  release_after_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_q) |-> ($past(dm_q) && !$past(dp_q)));

  // R11
  commit_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |-> done_q);

endmodule

// File: rtl/usb_ls_tx.sv
module usb_ls_tx #(
  parameter int CLKS_PER_BIT = 8,
  parameter int LEN_W        = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] pkt_len,
  input  logic [7:0]       byte_in,
  input  logic             addr_pending,
  output logic             byte_next,
  output logic             busy,
  output logic             done,
  output logic             addr_commit,
  output logic             dp,
  output logic             dm,
  output logic             oe
);

  logic [1:0]       rst_pipe_q;
  logic             rst_core_n;
  logic             tick, load, advance, timer_run;
  logic             need_toggle, bits_done;
  logic [LEN_W-1:0] n_bytes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  usbtx_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
    .clk   (clk),
    .rst_n (rst_core_n),
    .run   (timer_run),
    .tick  (tick)
  );

  usbtx_bit_source #(.LEN_W(LEN_W)) u_source (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .load        (load),
    .n_bytes     (n_bytes),
    .advance     (advance),
    .byte_in     (byte_in),
    .need_toggle (need_toggle),
    .bits_done   (bits_done),
    .byte_next   (byte_next)
  );

  usbtx_line_ctrl #(.LEN_W(LEN_W)) u_line (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .start        (start),
    .len_raw      (pkt_len),
    .addr_pending (addr_pending),
    .tick         (tick),
    .need_toggle  (need_toggle),
    .bits_done    (bits_done),
    .load         (load),
    .advance      (advance),
    .timer_run    (timer_run),
    .n_bytes      (n_bytes),
    .busy         (busy),
    .dp           (dp),
    .dm           (dm),
    .oe           (oe),
    .done         (done),
    .addr_commit  (addr_commit)
  );

endmodule

// File: tb/sim_usb_ls_tx.sv
`timescale 1ns/1ps
module sim_usb_ls_tx;

  localparam int P = 8;

  typedef struct packed {
    logic [3:0]  len;
    logic        pend;
    logic [87:0] data;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{4'd2,  1'b1, 88'hD2},
    '{4'd4,  1'b1, 88'hFFFFC3},
    '{4'd3,  1'b0, 88'hFF4B},
    '{4'd12, 1'b1, 88'h0FF03F7EFF00AA55E1FC5A},
    '{4'd0,  1'b1, 88'h5A},
    '{4'd15, 1'b1, 88'hFEFDFBF7EFDFBF7F0180C3}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [3:0] pkt_len;
  logic [7:0] byte_in;
  logic       addr_pending;
  logic       byte_next, busy, done, addr_commit, dp, dm, oe;

  int          total = 0;
  int          bad = 0;
  int          idx = 0;
  int          nxt_cnt = 0;
  logic [87:0] cur_data = '0;

  always #5 clk = ~clk;

  assign byte_in = (idx < 11) ? cur_data[idx*8 +: 8] : 8'h00;

  usb_ls_tx #(.CLKS_PER_BIT(P), .LEN_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .pkt_len(pkt_len),
    .byte_in(byte_in), .addr_pending(addr_pending), .byte_next(byte_next),
    .busy(busy), .done(done), .addr_commit(addr_commit),
    .dp(dp), .dm(dm), .oe(oe)
  );

  // byte source: advance after the edge that takes the byte
  always begin
    @(negedge clk);
    if (byte_next) begin
      @(posedge clk);
      #1;
      idx = idx + 1;
      nxt_cnt = nxt_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_pkt(input logic [3:0] len, input logic pend,
                         input logic [87:0] data, input bit inj);
    int clen;
    logic [1:0] syms [256];
    int nsym;
    bit se0;
    bit unstable;
    bit busy_lost;
    logic [1:0] s0;
    logic [1:0] prev;
    int ones;
    int nbits;
    logic [95:0] stream;
    logic [95:0] exp_bits;
    int stuff_bad;
    int bit_bad;
    int exp_sym;
    int run;
    bit eop_bad;
    clen = (len < 2) ? 2 : ((len > 12) ? 12 : int'(len));
    cur_data = data;
    idx = 0;
    nxt_cnt = 0;
    nsym = 0;
    se0 = 0;
    unstable = 0;
    busy_lost = 0;
    @(negedge clk);
    pkt_len = len;
    addr_pending = pend;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R2: one cycle of J with drivers off
    chk(oe == 1'b0 && dp == 1'b0 && dm == 1'b1 && busy == 1'b1, "R2",
        "prep {oe,dp,dm,busy}", int'({oe, dp, dm, busy}), 4'b0011);
    for (int k = 0; k < 200 && !se0; k++) begin
      @(negedge clk);
      s0 = {dp, dm};
      if (k == 0) chk(oe == 1'b1, "R2", "oe in first bit", int'(oe), 1);
      if (!busy) busy_lost = 1;
      if (inj && k == 5) begin
        start = 1'b1;
        pkt_len = 4'd12;
      end
      for (int j = 1; j < P; j++) begin
        @(negedge clk);
        start = 1'b0;
        if ({dp, dm} != s0 || !oe) unstable = 1;
        if (!busy) busy_lost = 1;
      end
      if (s0 == 2'b00) se0 = 1;
      else begin
        syms[nsym] = s0;
        nsym++;
      end
    end
    chk(!unstable, "R3", "symbol held for full bit", int'(unstable), 0);
    eop_bad = 0;
    for (int j = 0; j < P; j++) begin
      @(negedge clk);
      if ({dp, dm} != 2'b00 || !oe || !busy) eop_bad = 1;
    end
    chk(!eop_bad, "R9", "second SE0 bit", int'(eop_bad), 0);
    eop_bad = 0;
    for (int j = 0; j < P; j++) begin
      @(negedge clk);
      if ({dp, dm} != 2'b01 || !oe || !busy) eop_bad = 1;
    end
    chk(!eop_bad, "R9", "final J bit", int'(eop_bad), 0);
    @(negedge clk);
    chk(oe == 1'b0 && done == 1'b1 && busy == 1'b0, "R10",
        "release {oe,done,busy}", int'({oe, done, busy}), 3'b010);
    chk(addr_commit == (pend && clen > 2), "R11", "commit at release",
        int'(addr_commit), int'(pend && clen > 2));
    chk(!busy_lost, "R10", "busy held during packet", int'(busy_lost), 0);
    @(negedge clk);
    chk(done == 1'b0 && addr_commit == 1'b0 && {dp, dm} == 2'b00, "R1",
        "idle after done {done,commit,dp,dm}",
        int'({done, addr_commit, dp, dm}), 0);
    // independent NRZI / destuff decode
    exp_bits = {data, 8'h80};
    prev = 2'b01;
    ones = 0;
    nbits = 0;
    stream = '0;
    stuff_bad = 0;
    for (int i = 0; i < nsym; i++) begin
      logic b;
      if (syms[i] == 2'b11) stuff_bad++;
      b = (syms[i] == prev);
      prev = syms[i];
      if (ones == 6) begin
        if (b) stuff_bad++;
        ones = 0;
      end else begin
        if (nbits < 96) stream[nbits] = b;
        nbits++;
        ones = b ? ones + 1 : 0;
      end
    end
    if (ones == 6) stuff_bad++;
    // expected symbol count including stuffs
    run = 0;
    exp_sym = 0;
    for (int i = 0; i < clen * 8; i++) begin
      exp_sym++;
      run = exp_bits[i] ? run + 1 : 0;
      if (run == 6) begin
        exp_sym++;
        run = 0;
      end
    end
    chk(stuff_bad == 0 && nsym == exp_sym, "R6", "stuffed symbol count",
        nsym, exp_sym);
    chk(nbits == clen * 8, (len != 4'(clen)) ? "R8" : "R5",
        "decoded bit count", nbits, clen * 8);
    bit_bad = 0;
    for (int i = 0; i < clen * 8 && i < nbits; i++)
      if (stream[i] != exp_bits[i]) bit_bad++;
    chk(bit_bad == 0, "R5", "decoded bit mismatches", bit_bad, 0);
    chk(stream[7:0] == 8'h80, "R4", "sync byte", int'(stream[7:0]), 8'h80);
    if (nsym >= 8)
      chk(syms[0] == 2'b10 && syms[1] == 2'b01 && syms[6] == 2'b10 &&
          syms[7] == 2'b10, "R4", "sync symbols K J .. K K",
          int'({syms[0], syms[1], syms[6], syms[7]}), 8'b10011010);
    chk(nxt_cnt == clen - 1, "R7", "byte_next pulses", nxt_cnt, clen - 1);
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    total++;
    $display("FAIL R10 watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    pkt_len = 4'd2;
    addr_pending = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({oe, dp, dm, busy, done, addr_commit, byte_next} == 7'b0, "R1",
        "reset outputs", int'({oe, dp, dm, busy, done, addr_commit, byte_next}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({oe, dp, dm, busy, done} == 5'b0, "R1", "idle after reset",
        int'({oe, dp, dm, busy, done}), 0);

    for (int v = 0; v < NV; v++)
      run_pkt(VEC[v].len, VEC[v].pend, VEC[v].data, 1'b0);

    // R12: start during a packet is ignored
    run_pkt(4'd4, 1'b0, 88'h00FF81, 1'b1);
    chk(busy == 1'b0 && oe == 1'b0, "R12", "no second packet after ignored start",
        int'({busy, oe}), 0);

    // R11: data packet with no pending address
    run_pkt(4'd5, 1'b0, 88'h7FFFFFFE, 1'b0);

    // R1: reset in the middle of a packet
    @(negedge clk);
    cur_data = 88'hAAAA;
    idx = 0;
    pkt_len = 4'd3;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk({oe, busy, dp, dm} == 4'b0, "R1", "async reset mid packet",
        int'({oe, busy, dp, dm}), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({oe, busy} == 2'b0, "R1", "idle after mid-packet reset", int'({oe, busy}), 0);
    run_pkt(4'd2, 1'b1, 88'h5A, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule